// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command state machine between a CPU write port and a nonvolatile array controller. The CPU writes operand codes on the data lines. Most operations need two writes. The first write carries the operand. The second write carries the target address and data. The block then checks the enable bit of the addressed sector, runs the operation and reports the result in a status vector. A programmable run length (`op_time`) stands in for the array operation. The `fail_inject` input marks an operation as failed when it completes. The `vfault` input models a supply fault.

Program and erase operations can be parked with a suspend command and continued later with a resume command. A resume checks the sector enable bit again, as if the command were new. While the block is busy it takes only the data write of an armed command, or a suspend. When the read pipeline is enabled (`pipe_on`), the block refuses every write.

Top module: `flash_cmd_seq`

## Requirements
- R1: Operands are 0x0010 program, 0x0020 erase, 0x0040 clear status, 0x0080 suspend, 0x0200 resume program, 0x0400 resume erase, 0x0800 program one-time sector, 0x1000 validate. The bits of `status_o` are: bit0 busy, bit1 sector locked, bit2 command failed, bit3 supply fault, bit4 invalid data, bit5 program suspended, bit6 erase suspended. Every bit is 0 after reset.
- R2: Program, program one-time, erase and validate take the next accepted write as their address and data cycle, with no time limit. Busy is 1 from the edge that accepts the operand.
- R3: Clear status, written while idle, sets bits 1 to 4 to 0 on the next edge and does not raise busy. Written while busy, it is ignored.
- R4: While busy, every write other than the data cycle of an armed command or a suspend is ignored.
- R5: The sector index is `wr_addr[SEC_LSB +: log2(NSEC)]`. If the enable bit of that sector is 0 for a program or an erase, the edge after the data write sets bit1 and drops busy, and no run takes place. Validate does not check the enable bit.
- R6: For an operation that is not interrupted, busy falls on the edge that follows the data write by `op_time`+1 edges. A value of 0 is treated as 1.
- R7: A suspend accepted during a program or an erase drops busy within SUSP_LAT cycles and sets bit5 or bit6. Validate cannot be suspended.
- R8: If a suspend arrives in the last run cycle, the operation completes and no suspended bit is set.
- R9: A resume continues the suspended operation only when that operation is parked. The resume rechecks the enable bit, and a disabled sector sets bit1 and clears the suspended bit. A resume with nothing parked, or a suspend while idle, has no effect.
- R10: A program or program one-time operand is ignored while a program is parked. An erase operand is ignored while an erase is parked.
- R11: If `fail_inject` is 1 in the completing cycle, bit2 is set. For a program, bit4 is set as well.
- R12: If `vfault` is 1 in any run cycle of a program or an erase, bit3 and bit2 are set and the operation halts at once.
- R13: While `pipe_on` is 1, every write is refused, including a pending data cycle.
- R14: After completion the block is idle, so a further data-like write starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 16 | Write data or operand |
| sector_en | input | NSEC | Per-sector enable bits (1 = modifiable) |
| pipe_on | input | 1 | Read pipeline enabled; refuses writes |
| op_time | input | TW | Run length of an array operation, in cycles |
| fail_inject | input | 1 | Marks the completing operation as failed |
| vfault | input | 1 | Supply fault during program or erase |
| status_o | output | 7 | Busy and status flags |

## Verification
The assertions check the following on every cycle:
- busy falls within the suspend latency;
- a lock halt, a supply-fault halt and a completion each leave the block idle with the matching flag;
- clear status empties the error flags;
- writes refused under `pipe_on` never start anything.

Some behaviours only the directed scenarios can show:
- the exact completion cycle;
- a data cycle that waits with no time limit;
- filtering of commands during a run;
- refusal of a new program or erase while one of the same kind is parked;
- a suspend that lands in the last run cycle;
- the enable check repeated on resume.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [15:0] OPC_PROG  = 16'h0010;
  localparam logic [15:0] OPC_ERASE = 16'h0020;
  localparam logic [15:0] OPC_CLEAR = 16'h0040;
  localparam logic [15:0] OPC_SUSP  = 16'h0080;
  localparam logic [15:0] OPC_RES_P = 16'h0200;
  localparam logic [15:0] OPC_RES_E = 16'h0400;
  localparam logic [15:0] OPC_OTP   = 16'h0800;
  localparam logic [15:0] OPC_VALID = 16'h1000;

  typedef enum logic [3:0] {
    C_NONE, C_PROG, C_OTP, C_ERASE, C_VALID, C_CLEAR, C_SUSP, C_RES_P, C_RES_E
  } cmd_e;

  typedef enum logic [1:0] {K_PROG, K_ERASE, K_VALID} kind_e;

  typedef enum logic [2:0] {S_IDLE, S_ARMED, S_CHECK, S_RUN, S_DRAIN} state_e;

  // Operand word to command code; anything unlisted is no command.
  function automatic cmd_e decode_op(input logic [15:0] d);
    case (d)
      OPC_PROG:  return C_PROG;
      OPC_OTP:   return C_OTP;
      OPC_ERASE: return C_ERASE;
      OPC_VALID: return C_VALID;
      OPC_CLEAR: return C_CLEAR;
      OPC_SUSP:  return C_SUSP;
      OPC_RES_P: return C_RES_P;
      OPC_RES_E: return C_RES_E;
      default:   return C_NONE;
    endcase
  endfunction

  // Operation kind an arming command runs as.
  function automatic kind_e kind_of(input cmd_e c);
    case (c)
      C_ERASE: return K_ERASE;
      C_VALID: return K_VALID;
      default: return K_PROG;
    endcase
  endfunction

endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
  import flash_cmd_pkg::*;
(
  input  logic [15:0] data_i,
  output cmd_e        cmd_o
);
  always_comb cmd_o = decode_op(data_i);
endmodule

// File: rtl/fcs_timer.sv
// Remaining-run counter; a zero length is stretched to one cycle.
module fcs_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          tick_i,
  output logic [TW-1:0] rem_o,
  output logic          last_o
);
  function automatic logic [TW-1:0] clamp_len(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rem_o <= '0;
    else if (load_i)                 rem_o <= clamp_len(load_val_i);
    else if (tick_i && rem_o != '0)  rem_o <= rem_o - TW'(1);
  end

  assign last_o = (rem_o == TW'(1));
endmodule

// File: rtl/fcs_drain.sv
// Counts the cycles between an accepted suspend and the park point.
module fcs_drain #(
  parameter int SUSP_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int DW = $clog2(SUSP_LAT + 1) + 1;
  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (start_i)             cnt <= DW'(SUSP_LAT);
    else if (tick_i && cnt != '0) cnt <= cnt - DW'(1);
  end

  assign done_o = (cnt <= DW'(1));
endmodule

// File: rtl/fcs_flags.sv
// Sticky error flags: {invdat, vstat, cstat, slock}.
module fcs_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       set_slock_i,
  input  logic       set_cstat_i,
  input  logic       set_vstat_i,
  input  logic       set_invdat_i,
  output logic [3:0] flags_o
);
  logic [3:0] set_vec;
  assign set_vec = {set_invdat_i, set_vstat_i, set_cstat_i, set_slock_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flags_o <= '0;
    else if (clr_i) flags_o <= set_vec;
    else            flags_o <= flags_o | set_vec;
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 20,
  parameter int NSEC     = 32,
  parameter int SEC_LSB  = 10,
  parameter int TW       = 16,
  parameter int SUSP_LAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [15:0]     wr_data,
  input  logic [NSEC-1:0] sector_en,
  input  logic            pipe_on,
  input  logic [TW-1:0]   op_time,
  input  logic            fail_inject,
  input  logic            vfault,
  output logic [6:0]      status_o
);
  localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1;

  state_e        st;
  kind_e         kind;
  logic [SW-1:0] sec, p_sec, e_sec;
  logic [TW-1:0] p_rem, e_rem;
  logic          psusp, esusp;

  cmd_e          cmd;
  logic [TW-1:0] rem;
  logic          last, drain_done;
  logic [3:0]    flags;

  // Named internal events
  logic wr_ok, in_idle, running, suspendable;
  logic ev_arm, ev_clear, ev_res_p, ev_res_e, ev_data;
  logic ev_fault, ev_complete, ev_susp_take, ev_park, ev_lock;
  logic          load;
  logic [TW-1:0] load_val;

  fcs_decode u_dec (.data_i(wr_data), .cmd_o(cmd));

  always_comb begin
    wr_ok       = wr_en && !pipe_on;
    in_idle     = (st == S_IDLE);
    running     = (st == S_RUN) || (st == S_DRAIN);
    suspendable = (kind != K_VALID);

    ev_arm   = in_idle && wr_ok &&
               ((((cmd == C_PROG) || (cmd == C_OTP)) && !psusp) ||
                ((cmd == C_ERASE) && !esusp) || (cmd == C_VALID));
    ev_clear = in_idle && wr_ok && (cmd == C_CLEAR);
    ev_res_p = in_idle && wr_ok && (cmd == C_RES_P) && psusp;
    ev_res_e = in_idle && wr_ok && (cmd == C_RES_E) && esusp;
    ev_data  = (st == S_ARMED) && wr_ok;

    ev_lock      = (st == S_CHECK) && (kind != K_VALID) && !sector_en[sec];
    ev_fault     = running && suspendable && vfault;
    ev_complete  = running && !ev_fault && last;
    ev_susp_take = (st == S_RUN) && wr_ok && (cmd == C_SUSP) &&
                   suspendable && !ev_fault && !last;
    ev_park      = (st == S_DRAIN) && !ev_fault && !last && drain_done;

    load     = ev_data || ev_res_p || ev_res_e;
    load_val = ev_res_p ? p_rem : (ev_res_e ? e_rem : op_time);
  end

  fcs_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(load_val),
    .tick_i(running), .rem_o(rem), .last_o(last)
  );

  fcs_drain #(.SUSP_LAT(SUSP_LAT)) u_drain (
    .clk(clk), .rst_n(rst_n), .start_i(ev_susp_take),
    .tick_i(st == S_DRAIN), .done_o(drain_done)
  );

  fcs_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clr_i(ev_clear),
    .set_slock_i(ev_lock),
    .set_cstat_i(ev_fault || (ev_complete && fail_inject)),
    .set_vstat_i(ev_fault),
    .set_invdat_i(ev_complete && fail_inject && (kind == K_PROG)),
    .flags_o(flags)
  );

  // Sequencer state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      kind <= K_PROG;
      sec <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (ev_arm) begin
            st   <= S_ARMED;
            kind <= kind_of(cmd);
          end else if (ev_res_p) begin
            st <= S_CHECK; kind <= K_PROG; sec <= p_sec;
          end else if (ev_res_e) begin
            st <= S_CHECK; kind <= K_ERASE; sec <= e_sec;
          end
        end
        S_ARMED: if (ev_data) begin
          st  <= S_CHECK;
          sec <= wr_addr[SEC_LSB +: SW];
        end
        S_CHECK: st <= ev_lock ? S_IDLE : S_RUN;
        S_RUN: begin
          if (ev_fault || ev_complete) st <= S_IDLE;
          else if (ev_susp_take)       st <= S_DRAIN;
        end
        S_DRAIN: if (ev_fault || ev_complete || ev_park) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // Parked operations
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psusp <= 1'b0; esusp <= 1'b0;
      p_rem <= '0;   e_rem <= '0;
      p_sec <= '0;   e_sec <= '0;
    end else begin
      if (ev_res_p) psusp <= 1'b0;
      if (ev_res_e) esusp <= 1'b0;
      if (ev_park) begin
        if (kind == K_PROG) begin
          psusp <= 1'b1; p_rem <= rem - TW'(1); p_sec <= sec;
        end else begin
          esusp <= 1'b1; e_rem <= rem - TW'(1); e_sec <= sec;
        end
      end
    end
  end

  assign status_o = {esusp, psusp, flags, (st != S_IDLE)};

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int SUSP_LAT = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] status,
  input logic       pipe_on,
  input logic       ev_clear,
  input logic       ev_lock,
  input logic       ev_fault,
  input logic       ev_complete,
  input logic       ev_susp_take,
  input logic       ev_park
);
  localparam int CW = $clog2(SUSP_LAT + 2) + 1;
  logic [CW-1:0] scnt;
  logic          track;
  logic          busy;
  assign busy = status[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      track <= 1'b0; scnt <= '0;
    end else if (ev_susp_take) begin
      track <= 1'b1; scnt <= CW'(1);
    end else if (track && busy) begin
      if (scnt != '1) scnt <= scnt + CW'(1);
    end else begin
      track <= 1'b0;
    end
  end

  assert_susp_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (track && busy) |-> (scnt <= CW'(SUSP_LAT)));

  assert_park_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_park |=> (!busy && (status[5] || status[6])));

  assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clear |=> (status[4:1] == 4'b0 && !busy));

  assert_lock_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock |=> (status[1] && !busy));

  assert_fault_halts_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> (status[3] && status[2] && !busy));

  assert_complete_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_complete |=> !busy);

  assert_pipe_refuse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_on && !busy) |=> !busy);
endmodule

bind flash_cmd_seq fcs_checker #(.SUSP_LAT(SUSP_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .status(status_o), .pipe_on(pipe_on),
  .ev_clear(ev_clear), .ev_lock(ev_lock), .ev_fault(ev_fault),
  .ev_complete(ev_complete), .ev_susp_take(ev_susp_take), .ev_park(ev_park)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int AW = 20, NSEC = 32, TW = 16, SUSP_LAT = 2;

  localparam logic [15:0] P_PROG = 16'h0010, P_ERASE = 16'h0020, P_CLEAR = 16'h0040,
                          P_SUSP = 16'h0080, P_RESP = 16'h0200, P_RESE = 16'h0400,
                          P_OTP = 16'h0800, P_VALID = 16'h1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [NSEC-1:0] sector_en = '1;
  logic pipe_on = 1'b0;
  logic [TW-1:0] op_time = 16'd5;
  logic fail_inject = 1'b0, vfault = 1'b0;
  logic [6:0] status_o;

  int checks = 0, errors = 0;

  flash_cmd_seq #(.AW(AW), .NSEC(NSEC), .TW(TW), .SUSP_LAT(SUSP_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sector_en(sector_en), .pipe_on(pipe_on), .op_time(op_time),
    .fail_inject(fail_inject), .vfault(vfault), .status_o(status_o)
  );

  always #10 clk = ~clk;

  function automatic logic [AW-1:0] sa(input int s);
    return AW'(s) << 10;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [AW-1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 2000; i++) begin
      if (!status_o[0]) return;
      @(negedge clk);
    end
    check(32'(status_o[0]), 0, req);
  endtask

  task automatic do_clear();
    cpu_wr('0, P_CLEAR);
  endtask

  task automatic t_reset();
    check(32'(status_o), 0, "R1 reset status");
  endtask

  task automatic t_program();
    op_time = 16'd5;
    cpu_wr('0, P_PROG);
    check(32'(status_o[0]), 1, "R2 busy after operand");
    cpu_wr(sa(3), 16'hABCD);
    repeat (5) @(negedge clk);
    check(32'(status_o[0]), 1, "R6 busy during run");
    @(negedge clk);
    check(32'(status_o), 0, "R6 done on time");
    cpu_wr(sa(3), 16'h1234);
    check(32'(status_o[0]), 0, "R14 idle after completion");
  endtask

  task automatic t_armed_wait();
    op_time = 16'd3;
    cpu_wr('0, P_OTP);
    repeat (40) @(negedge clk);
    check(32'(status_o[0]), 1, "R2 waits for data cycle");
    cpu_wr(sa(5), 16'h0F0F);
    wait_idle("R2 armed op completes");
    check(32'(status_o), 0, "R2 clean status");
  endtask

  task automatic t_lock();
    op_time = 16'd4;
    sector_en[4] = 1'b0;
    cpu_wr('0, P_ERASE);
    cpu_wr(sa(4), 16'h0000);
    @(negedge clk);
    check(32'(status_o), 32'h02, "R5 locked sector halts");
    cpu_wr('0, P_VALID);
    cpu_wr(sa(4), 16'h0000);
    @(negedge clk);
    check(32'(status_o[0]), 1, "R5 validate ignores enable");
    wait_idle("R5 validate ends");
    check(32'(status_o), 32'h02, "R5 flag kept");
    sector_en[4] = 1'b1;
    do_clear();
    check(32'(status_o), 0, "R3 clear status");
  endtask

  task automatic t_fail();
    op_time = 16'd3;
    fail_inject = 1'b1;
    cpu_wr('0, P_PROG);
    cpu_wr(sa(1), 16'h5555);
    wait_idle("R11 program ends");
    fail_inject = 1'b0;
    check(32'(status_o), 32'h14, "R11 program fail flags");
    op_time = 16'd8;
    cpu_wr('0, P_PROG);
    cpu_wr(sa(1), 16'h5555);
    cpu_wr('0, P_CLEAR);
    wait_idle("R4 run ends");
    check(32'(status_o), 32'h14, "R3 clear while busy ignored");
    do_clear();
    fail_inject = 1'b1;
    op_time = 16'd3;
    cpu_wr('0, P_ERASE);
    cpu_wr(sa(2), 16'h0);
    wait_idle("R11 erase ends");
    fail_inject = 1'b0;
    check(32'(status_o), 32'h04, "R11 erase fail flag");
    do_clear();
  endtask

  task automatic t_vfault();
    op_time = 16'd20;
    cpu_wr('0, P_ERASE);
    cpu_wr(sa(2), 16'h0);
    repeat (3) @(negedge clk);
    vfault = 1'b1;
    @(negedge clk);
    vfault = 1'b0;
    check(32'(status_o), 32'h0C, "R12 supply fault halts");
    do_clear();
  endtask

  task automatic t_busy_filter();
    op_time = 16'd10;
    cpu_wr('0, P_PROG);
    cpu_wr(sa(3), 16'h1);
    @(negedge clk);
    cpu_wr('0, P_ERASE);
    wait_idle("R4 run ends");
    cpu_wr(sa(3), 16'h0000);
    check(32'(status_o), 0, "R4 command during busy ignored");
  endtask

  task automatic t_suspend_prog();
    op_time = 16'd30;
    cpu_wr('0, P_PROG);
    cpu_wr(sa(2), 16'h7);
    repeat (5) @(negedge clk);
    cpu_wr('0, P_SUSP);
    repeat (SUSP_LAT - 1) @(negedge clk);
    check(32'(status_o[0]), 1, "R7 drain still busy");
    @(negedge clk);
    check(32'(status_o), 32'h20, "R7 program parked");
    cpu_wr('0, P_PROG);
    check(32'(status_o), 32'h20, "R10 program refused while parked");
    cpu_wr('0, P_OTP);
    check(32'(status_o), 32'h20, "R10 otp refused while parked");
    op_time = 16'd4;
    cpu_wr('0, P_ERASE);
    cpu_wr(sa(7), 16'h0);
    wait_idle("R10 erase during park");
    check(32'(status_o), 32'h20, "R10 erase allowed while program parked");
    cpu_wr('0, P_RESP);
    check(32'(status_o), 32'h01, "R9 resume busy");
    wait_idle("R9 resumed ends");
    check(32'(status_o), 0, "R9 resumed completes");
  endtask

  task automatic t_resume_lock();
    op_time = 16'd30;
    cpu_wr('0, P_PROG);
    cpu_wr(sa(6), 16'h9);
    repeat (4) @(negedge clk);
    cpu_wr('0, P_SUSP);
    wait_idle("R9 park");
    sector_en[6] = 1'b0;
    cpu_wr('0, P_RESP);
    @(negedge clk);
    check(32'(status_o), 32'h02, "R9 resume rechecks enable");
    sector_en[6] = 1'b1;
    do_clear();
  endtask

  task automatic t_erase_susp();
    op_time = 16'd30;
    cpu_wr('0, P_ERASE);
    cpu_wr(sa(1), 16'h0);
    repeat (4) @(negedge clk);
    cpu_wr('0, P_SUSP);
    wait_idle("R7 erase park");
    check(32'(status_o), 32'h40, "R7 erase parked");
    cpu_wr('0, P_ERASE);
    check(32'(status_o), 32'h40, "R10 erase refused while parked");
    op_time = 16'd3;
    cpu_wr('0, P_PROG);
    cpu_wr(sa(9), 16'h3);
    wait_idle("R10 program during erase park");
    check(32'(status_o), 32'h40, "R10 program ran");
    cpu_wr('0, P_RESE);
    wait_idle("R9 erase resume");
    check(32'(status_o), 0, "R9 erase resumed");
  endtask

  task automatic t_last_cycle();
    op_time = 16'd6;
    cpu_wr('0, P_PROG);
    cpu_wr(sa(2), 16'h2);
    repeat (6) @(negedge clk);
    check(32'(status_o[0]), 1, "R8 still in last cycle");
    cpu_wr('0, P_SUSP);
    check(32'(status_o), 0, "R8 last-cycle suspend finishes");
  endtask

  task automatic t_validate();
    op_time = 16'd15;
    cpu_wr('0, P_VALID);
    cpu_wr(sa(2), 16'h0);
    repeat (3) @(negedge clk);
    cpu_wr('0, P_SUSP);
    repeat (SUSP_LAT + 1) @(negedge clk);
    check(32'(status_o[0]), 1, "R7 validate not suspended");
    wait_idle("R7 validate ends");
    check(32'(status_o), 0, "R7 no park flag");
  endtask

  task automatic t_noeffect();
    cpu_wr('0, P_SUSP);
    check(32'(status_o), 0, "R9 idle suspend no effect");
    cpu_wr('0, P_RESP);
    check(32'(status_o), 0, "R9 resume program none parked");
    cpu_wr('0, P_RESE);
    check(32'(status_o), 0, "R9 resume erase none parked");
  endtask

  task automatic t_pipe();
    op_time = 16'd3;
    pipe_on = 1'b1;
    cpu_wr('0, P_PROG);
    check(32'(status_o), 0, "R13 operand refused");
    pipe_on = 1'b0;
    cpu_wr(sa(1), 16'h1234);
    check(32'(status_o), 0, "R13 nothing armed");
    cpu_wr('0, P_PROG);
    pipe_on = 1'b1;
    cpu_wr(sa(1), 16'h1);
    repeat (10) @(negedge clk);
    check(32'(status_o), 32'h01, "R13 data cycle refused");
    pipe_on = 1'b0;
    cpu_wr(sa(1), 16'h1);
    wait_idle("R13 op ends");
    check(32'(status_o), 0, "R13 op completes");
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_armed_wait();
    t_lock();
    t_fail();
    t_vfault();
    t_busy_filter();
    t_suspend_prog();
    t_resume_lock();
    t_erase_susp();
    t_last_cycle();
    t_validate();
    t_noeffect();
    t_pipe();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule